// File: doc/BRIEF.md
# In-Order Data Ordering Scoreboard

This block is a pass/fail checker placed beside a design under test. Helper logic offers each word the design is expected to produce, together with a strobe. The block keeps those words in arrival order. Whenever the design strobes out a produced word, the block compares it with the oldest expected word still outstanding and then retires that expected word. A wrong value or a wrong order shows up as a mismatch. A missing word or an extra word shows up as an underflow, or as a pending count that is not zero at the end of a test. A push into full storage shows up as an overflow.

Both word streams are valid-only streams. The checker never applies back-pressure, so a strobe is always taken in the cycle it is seen, and there is no ready signal on either side. The violation outputs are sticky until the synchronous reset. A single-cycle mismatch pulse marks the exact failing pop, and the first mismatching pair of words is held for debug.

A tracking mode narrows the comparison to one chosen word. Every word is still stored and retired, but only the pop whose ordinal number equals a static index is compared. This lets a single word be followed on its own.

Top module: `order_scoreboard`

## Requirements
- R1: Expected words are retired strictly in the order they were pushed. Each accepted pop is compared with the oldest stored word, and that word is then removed.
- R2: `mm_pulse` is combinational. It is high in the very cycle of an accepted pop whose produced word differs from the compared expected word, and low in every other cycle.
- R3: `err` rises one clock after any mismatch, underflow or overflow event and stays high until reset.
- R4: A pop while `pend_cnt` is 0 sets the sticky `uflow` flag and `err` on the next clock. A push in that same cycle does not satisfy the pop: the pushed word is stored, so `pend_cnt` becomes 1.
- R5: A push while `pend_cnt` equals DEPTH sets the sticky `oflow` flag and `err`, and the pushed word is dropped. A pop in the same cycle is still honoured, so `pend_cnt` becomes DEPTH-1.
- R6: `pend_cnt` counts the stored words and `empty` is high exactly when that count is 0. A push and a pop in the same cycle with storage neither empty nor full leave the count unchanged.
- R7: On the first mismatch after reset, `dbg_exp` and `dbg_got` capture the expected and produced words. Later mismatches leave them unchanged.
- R8: While `trk_en` is high, only the pop whose zero-based ordinal since reset equals `trk_idx` is compared. The other pops retire their words and cannot pulse `mm_pulse`.
- R9: A high `rst` at a rising edge clears the stored words, `pend_cnt`, the pop ordinal, every flag and the debug words.
- R10: Both strobes are accepted in the cycle they are high, without any handshake. Pushes and pops on consecutive cycles are all counted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| exp_valid | input | 1 | Push strobe for the expected word |
| exp_data | input | DATA_W | Expected word from helper logic |
| dut_valid | input | 1 | Pop strobe from the design under test |
| dut_data | input | DATA_W | Produced word from the design under test |
| trk_en | input | 1 | Static: compare only the selected pop |
| trk_idx | input | IDX_W | Static: ordinal of the pop compared in tracking mode |
| err | output | 1 | Sticky violation flag |
| uflow | output | 1 | Sticky underflow flag |
| oflow | output | 1 | Sticky overflow flag |
| mm_pulse | output | 1 | Same-cycle mismatch marker |
| pend_cnt | output | $clog2(DEPTH+1) | Number of outstanding expected words |
| empty | output | 1 | No outstanding expected word |
| dbg_exp | output | DATA_W | Expected word of the first mismatch |
| dbg_got | output | DATA_W | Produced word of the first mismatch |

## Verification
Push and pop can fall in the same cycle, and the bench drives them together in three states of the storage. When the storage is empty, the pop must be judged an underflow while the pushed word is kept. When it is full, the push must be dropped as an overflow while the pop still retires a word. When it is partly filled, both must be honoured and the count must hold. A queue-based model in the bench predicts the pulse before each edge and the count and flags after it, and these are compared with the ports every cycle.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef struct packed {
    logic mismatch;
    logic underflow;
    logic overflow;
  } sb_evt_t;

  function automatic logic sb_any(sb_evt_t e);
    return e.mismatch | e.underflow | e.overflow;
  endfunction
endpackage

// File: rtl/sb_store.sv
module sb_store #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head_data,
  output logic [CW-1:0]     count,
  output logic              push_ok,
  output logic              pop_ok,
  output logic              full,
  output logic              empty
);
  logic [DATA_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wr_ptr, rd_ptr;
  logic [CW-1:0]     count_q;

  function automatic logic [AW-1:0] ptr_next(logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full    = (count_q == CW'(DEPTH));
  assign empty   = (count_q == '0);
  assign push_ok = push & ~full;
  assign pop_ok  = pop & ~empty;
  assign count   = count_q;
  assign head_data = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr  <= '0;
      rd_ptr  <= '0;
      count_q <= '0;
    end else begin
      if (push_ok) wr_ptr <= ptr_next(wr_ptr);
      if (pop_ok)  rd_ptr <= ptr_next(rd_ptr);
      case ({push_ok, pop_ok})
        2'b10:   count_q <= count_q + 1'b1;
        2'b01:   count_q <= count_q - 1'b1;
        default: count_q <= count_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= push_data;
  end

  AST_NO_STORE_WHEN_FULL: assert property (@(posedge clk) disable iff (rst)
    push && full && !pop |=> full); // R5
  AST_FULL_POP_DROPS_PUSH: assert property (@(posedge clk) disable iff (rst)
    push && full && pop |=> count_q == CW'(DEPTH - 1)); // R5
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (rst)
    push_ok && pop_ok |=> $stable(count_q)); // R6
  AST_EMPTY_POP_NO_MOVE: assert property (@(posedge clk) disable iff (rst)
    pop && empty && !push |=> empty); // R4
endmodule

// File: rtl/sb_cmp.sv
module sb_cmp #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              pop_ok,
  input  logic [DATA_W-1:0] head_data,
  input  logic [DATA_W-1:0] got_data,
  input  logic              trk_en,
  input  logic [IDX_W-1:0]  trk_idx,
  output logic              mismatch
);
  logic [IDX_W-1:0] pop_num;
  logic             selected;

  always_ff @(posedge clk) begin
    if (rst)         pop_num <= '0;
    else if (pop_ok) pop_num <= pop_num + 1'b1;
  end

  assign selected = ~trk_en | (pop_num == trk_idx);
  assign mismatch = pop_ok & selected & (head_data != got_data);

  AST_POPNUM_STEP: assert property (@(posedge clk) disable iff (rst)
    pop_ok |=> pop_num == $past(pop_num) + 1'b1); // R8
  AST_POPNUM_IDLE: assert property (@(posedge clk) disable iff (rst)
    !pop_ok |=> $stable(pop_num)); // R8
endmodule

// File: rtl/sb_flags.sv
module sb_flags
  import sb_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  sb_evt_t           evt,
  input  logic [DATA_W-1:0] exp_word,
  input  logic [DATA_W-1:0] got_word,
  output logic              err,
  output logic              uflow,
  output logic              oflow,
  output logic [DATA_W-1:0] dbg_exp,
  output logic [DATA_W-1:0] dbg_got
);
  logic mm_seen;

  always_ff @(posedge clk) begin
    if (rst) begin
      err     <= 1'b0;
      uflow   <= 1'b0;
      oflow   <= 1'b0;
      mm_seen <= 1'b0;
      dbg_exp <= '0;
      dbg_got <= '0;
    end else begin
      if (sb_any(evt))   err   <= 1'b1;
      if (evt.underflow) uflow <= 1'b1;
      if (evt.overflow)  oflow <= 1'b1;
      if (evt.mismatch && !mm_seen) begin
        mm_seen <= 1'b1;
        dbg_exp <= exp_word;
        dbg_got <= got_word;
      end
    end
  end

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err |=> err); // R3
  AST_MM_SETS_ERR: assert property (@(posedge clk) disable iff (rst)
    evt.mismatch |=> err); // R3
  AST_UF_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    evt.underflow |=> uflow && err); // R4
  AST_OF_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    evt.overflow |=> oflow && err); // R5
  AST_DBG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    mm_seen |=> $stable(dbg_exp) && $stable(dbg_got)); // R7
endmodule

// File: rtl/order_scoreboard.sv
module order_scoreboard
  import sb_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int IDX_W  = 8,
  localparam int CW = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              exp_valid,
  input  logic [DATA_W-1:0] exp_data,
  input  logic              dut_valid,
  input  logic [DATA_W-1:0] dut_data,
  input  logic              trk_en,
  input  logic [IDX_W-1:0]  trk_idx,
  output logic              err,
  output logic              uflow,
  output logic              oflow,
  output logic              mm_pulse,
  output logic [CW-1:0]     pend_cnt,
  output logic              empty,
  output logic [DATA_W-1:0] dbg_exp,
  output logic [DATA_W-1:0] dbg_got
);
  logic [DATA_W-1:0] head_data;
  logic              push_ok, pop_ok, full, st_empty, mismatch;
  sb_evt_t           evt;

  sb_store #(.DATA_W(DATA_W), .DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst       (rst),
    .push      (exp_valid),
    .push_data (exp_data),
    .pop       (dut_valid),
    .head_data (head_data),
    .count     (pend_cnt),
    .push_ok   (push_ok),
    .pop_ok    (pop_ok),
    .full      (full),
    .empty     (st_empty)
  );

  sb_cmp #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_cmp (
    .clk       (clk),
    .rst       (rst),
    .pop_ok    (pop_ok),
    .head_data (head_data),
    .got_data  (dut_data),
    .trk_en    (trk_en),
    .trk_idx   (trk_idx),
    .mismatch  (mismatch)
  );

  always_comb begin
    evt.mismatch  = mismatch;
    evt.underflow = dut_valid & st_empty;
    evt.overflow  = exp_valid & full;
  end

  sb_flags #(.DATA_W(DATA_W)) u_flags (
    .clk      (clk),
    .rst      (rst),
    .evt      (evt),
    .exp_word (head_data),
    .got_word (dut_data),
    .err      (err),
    .uflow    (uflow),
    .oflow    (oflow),
    .dbg_exp  (dbg_exp),
    .dbg_got  (dbg_got)
  );

  assign mm_pulse = mismatch;
  assign empty    = st_empty;

  AST_PULSE_ONLY_ON_POP: assert property (@(posedge clk) disable iff (rst)
    mm_pulse |-> dut_valid && !empty); // R2
  AST_COUNT_BOUND: assert property (@(posedge clk) disable iff (rst)
    pend_cnt <= CW'(DEPTH)); // R6
  AST_PUSH_COUNTED: assert property (@(posedge clk) disable iff (rst)
    exp_valid && !dut_valid && !full |=> pend_cnt == $past(pend_cnt) + 1'b1); // R10
endmodule

// File: tb/order_scoreboard_tb.sv
module order_scoreboard_tb_top;
  localparam int DATA_W = 32;
  localparam int DEPTH  = 16;
  localparam int IDX_W  = 8;
  localparam int CW     = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic exp_valid = 1'b0, dut_valid = 1'b0, trk_en = 1'b0;
  logic [DATA_W-1:0] exp_data = '0, dut_data = '0;
  logic [IDX_W-1:0]  trk_idx = '0;
  logic err, uflow, oflow, mm_pulse, empty;
  logic [CW-1:0] pend_cnt;
  logic [DATA_W-1:0] dbg_exp, dbg_got;

  always #4 clk = ~clk;

  order_scoreboard #(.DATA_W(DATA_W), .DEPTH(DEPTH), .IDX_W(IDX_W)) dut_i (
    .clk(clk), .rst(rst), .exp_valid(exp_valid), .exp_data(exp_data),
    .dut_valid(dut_valid), .dut_data(dut_data), .trk_en(trk_en), .trk_idx(trk_idx),
    .err(err), .uflow(uflow), .oflow(oflow), .mm_pulse(mm_pulse),
    .pend_cnt(pend_cnt), .empty(empty), .dbg_exp(dbg_exp), .dbg_got(dbg_got));

  int checks = 0;
  int fails  = 0;

  logic [DATA_W-1:0] q[$];
  bit m_err, m_uf, m_of, m_seen;
  logic [DATA_W-1:0] m_dexp, m_dgot;
  int m_popn;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  function automatic bit pred_mm();
    if (!dut_valid || q.size() == 0) return 1'b0;
    if (trk_en && m_popn != int'(trk_idx)) return 1'b0;
    return q[0] != dut_data;
  endfunction

  task automatic model_reset();
    q.delete();
    m_err = 0; m_uf = 0; m_of = 0; m_seen = 0;
    m_dexp = '0; m_dgot = '0; m_popn = 0;
  endtask

  task automatic check_state(input string req);
    chk(pend_cnt == CW'(q.size()), req, "pend_cnt", pend_cnt, q.size());
    chk(empty == (q.size() == 0), req, "empty", empty, q.size() == 0);
    chk(err == m_err, "R3", "err", err, m_err);
    chk(uflow == m_uf, "R4", "uflow", uflow, m_uf);
    chk(oflow == m_of, "R5", "oflow", oflow, m_of);
    chk(dbg_exp == m_dexp, "R7", "dbg_exp", dbg_exp, m_dexp);
    chk(dbg_got == m_dgot, "R7", "dbg_got", dbg_got, m_dgot);
  endtask

  // One clock: drive at negedge, check the pulse before the edge, update model, check after.
  task automatic step(input bit ps, input logic [DATA_W-1:0] pd,
                      input bit pp, input logic [DATA_W-1:0] gd, input string req);
    bit mm, ovf, uf;
    int sz;
    @(negedge clk);
    exp_valid = ps; exp_data = pd; dut_valid = pp; dut_data = gd;
    #1;
    mm = pred_mm();
    chk(mm_pulse == mm, (req == "R8") ? "R8" : "R2", "mm_pulse", mm_pulse, mm);
    sz  = q.size();
    ovf = ps && sz == DEPTH;
    uf  = pp && sz == 0;
    @(posedge clk);
    #1;
    if (rst) model_reset();
    else begin
      if (mm && !m_seen) begin m_seen = 1; m_dexp = q[0]; m_dgot = gd; end
      if (pp && sz > 0) begin void'(q.pop_front()); m_popn++; end
      if (ps && !ovf) q.push_back(pd);
      if (mm || ovf || uf) m_err = 1;
      if (uf) m_uf = 1;
      if (ovf) m_of = 1;
    end
    check_state(req);
  endtask

  task automatic do_reset();
    rst = 1'b1;
    step(0, '0, 0, '0, "R9");
    step(0, '0, 0, '0, "R9");
    rst = 1'b0;
  endtask

  initial begin : watchdog
    #(8 * 20000);
    fails++;
    $display("FAIL watchdog expired: actual running expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    do_reset();
    chk(pend_cnt == 0 && empty && !err, "R9", "reset state", {pend_cnt, empty, err}, 2);

    // R1 in order words, then a corrupted third word (R2, R3, R7)
    for (int i = 0; i < 3; i++) step(1, 32'hA000_0000 + i, 0, '0, "R10");
    step(0, '0, 1, 32'hA000_0000, "R1");
    step(0, '0, 1, 32'hA000_0001, "R1");
    chk(!err, "R1", "no error after matching pops", err, 0);
    step(0, '0, 1, 32'hDEAD_BEEF, "R2");
    chk(err && dbg_exp == 32'hA000_0002, "R7", "first capture", dbg_exp, 32'hA000_0002);
    step(0, '0, 0, '0, "R3");
    do_reset();

    // R1 out of order pair, second mismatch must not overwrite capture (R7)
    step(1, 32'h11, 0, '0, "R10");
    step(1, 32'h22, 0, '0, "R10");
    step(0, '0, 1, 32'h22, "R1");
    step(0, '0, 1, 32'h11, "R7");
    do_reset();

    // R4 underflow with same cycle push
    step(1, 32'h55, 1, 32'h55, "R4");
    chk(uflow && pend_cnt == 1, "R4", "underflow keeps push", pend_cnt, 1);
    step(0, '0, 1, 32'h55, "R4");
    do_reset();

    // R5 overflow, then push and pop while full
    for (int i = 0; i < DEPTH; i++) step(1, 32'hB00 + i, 0, '0, "R6");
    chk(!err && pend_cnt == DEPTH, "R6", "full count", pend_cnt, DEPTH);
    step(1, 32'hFFFF, 0, '0, "R5");
    step(1, 32'hEEEE, 1, 32'hB00, "R5");
    chk(pend_cnt == DEPTH - 1, "R5", "full push+pop", pend_cnt, DEPTH - 1);
    for (int i = 1; i < DEPTH; i++) step(0, '0, 1, 32'hB00 + i, "R1");
    do_reset();

    // R6 simultaneous push and pop on partly filled storage
    step(1, 32'h100, 0, '0, "R6");
    for (int i = 1; i < 6; i++) step(1, 32'h100 + i, 1, 32'h100 + i - 1, "R6");
    step(0, '0, 1, 32'h105, "R6");
    chk(!err && empty, "R6", "stream drained clean", err, 0);
    do_reset();

    // R8 tracking mode: only pop number 2 is compared
    trk_en = 1'b1; trk_idx = 8'd2;
    do_reset();
    for (int i = 0; i < 4; i++) step(1, 32'h300 + i, 0, '0, "R10");
    step(0, '0, 1, 32'h0BAD, "R8");
    step(0, '0, 1, 32'h0BAD, "R8");
    chk(!err, "R8", "untracked pops ignored", err, 0);
    step(0, '0, 1, 32'h0BAD, "R8");
    step(0, '0, 1, 32'h0BAD, "R8");
    trk_en = 1'b0; trk_idx = '0;
    do_reset();

    // R6 leftover words stay visible
    step(1, 32'h7, 0, '0, "R6");
    step(1, 32'h8, 0, '0, "R6");
    chk(pend_cnt == 2 && !empty, "R6", "leftover count", pend_cnt, 2);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule